// File: doc/BRIEF.md
# Prescaled Countdown Timer

This block is a reloading down-counter for a timekeeping device. Four tick strobes come from an external prescaler chain, one for each source frequency: 4096 Hz, 64 Hz, 1 Hz and 1/60 Hz. A two-bit select picks which strobe drives the counter. Software writes a period value. When the counter runs out, the block reloads that period, raises a sticky timer flag and keeps counting while it is enabled.

The interrupt request is shared with an alarm whose flag and enable come in from outside the block. The timer's share of the request can work in one of two modes. In level mode it follows the flag. In pulse mode it lasts one source period after each expiry and does not depend on the flag. The bus decoding, the register file and the prescaler are outside the block. Writes reach the block as strobes (`ld_stb` and `flag_wr`), and the control bits are static inputs.

Top module: `prescaled_countdown`

## Requirements
- R1: After reset, `count` is 0, `tmr_flag` is 0 and `irq` is 0 while the alarm inputs are low.
- R2: `src_sel` picks the counting strobe: 0 selects `src_tick[0]` (4096 Hz), 1 selects `src_tick[1]` (64 Hz), 2 selects `src_tick[2]` (1 Hz) and 3 selects `src_tick[3]` (1/60 Hz). Strobes on the other three lines leave `count` unchanged.
- R3: While `tmr_en` is 0, `count` holds its value and ticks have no effect.
- R4: After reset, after `tmr_en` has been low, or after a load, the first selected tick copies the stored period into `count` and does not decrement it.
- R5: Every other selected tick decrements `count`. A tick that finds `count` at 1 or 0 is an expiry: `count` reloads the period and `tmr_flag` is set. With period N, the flag rises on the Nth tick after the starting tick.
- R6: `tmr_flag` stays set until a `flag_wr` cycle with `flag_wdata`=0. A write with `flag_wdata`=1 has no effect. An expiry in the same cycle as a clearing write wins.
- R7: In level mode (`pulse_mode`=0), the timer part of `irq` equals `tmr_flag & tmr_ie`.
- R8: In pulse mode (`pulse_mode`=1), the timer part of `irq` is high from the cycle after an expiry until the next selected tick, gated by `tmr_ie`. It does not depend on `tmr_flag`.
- R9: `irq` also goes high whenever `alm_flag & alm_ie` is high, in both modes, in the same cycle.
- R10: `ld_stb` stores `ld_val` as the new period and does not change `count` in that cycle. The next selected tick starts from the new value, as in R4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_tick | input | 4 | One-cycle strobes of the four source frequencies |
| src_sel | input | 2 | Source select |
| tmr_en | input | 1 | Countdown enable |
| ld_stb | input | 1 | Period write strobe |
| ld_val | input | 8 | Period value to store |
| flag_wr | input | 1 | Flag write strobe |
| flag_wdata | input | 1 | Flag write data (only 0 acts) |
| tmr_ie | input | 1 | Timer interrupt enable |
| pulse_mode | input | 1 | 1 = pulsed timer interrupt, 0 = level |
| alm_flag | input | 1 | Alarm flag |
| alm_ie | input | 1 | Alarm interrupt enable |
| tmr_flag | output | 1 | Sticky timer flag |
| count | output | 8 | Current count |
| irq | output | 1 | Combined interrupt request |

## Verification
`count`, `tmr_flag` and the pulse state are registered, so they change on the clock edge that samples a tick or write strobe. The bench drives each strobe for one cycle from a falling edge and checks these outputs at the next falling edge. `irq` is a combinational function of registered state and the enable, mode and alarm inputs. The bench therefore checks it in the same way after a state change, and 1 ns after a static input change. The cases covered are ticks on sources that are not selected, same-cycle load and tick, and same-cycle expiry and flag clear, each sampled in the cycle that follows the strobe.

// File: rtl/prescaled_countdown.sv
module prescaled_countdown #(
  parameter int W    = 8,
  parameter int NSRC = 4,
  localparam int SELW = $clog2(NSRC)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] src_tick,
  input  logic [SELW-1:0] src_sel,
  input  logic            tmr_en,
  input  logic            ld_stb,
  input  logic [W-1:0]    ld_val,
  input  logic            flag_wr,
  input  logic            flag_wdata,
  input  logic            tmr_ie,
  input  logic            pulse_mode,
  input  logic            alm_flag,
  input  logic            alm_ie,
  output logic            tmr_flag,
  output logic [W-1:0]    count,
  output logic            irq
);

  logic [W-1:0] per_q, cnt_q;
  logic         pend_q, flag_q, pulse_q;

  wire tk     = tmr_en & src_tick[src_sel];
  wire run    = tk & ~ld_stb;
  wire expire = run & ~pend_q & (cnt_q <= W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      per_q   <= '0;
      cnt_q   <= '0;
      pend_q  <= 1'b1;
      flag_q  <= 1'b0;
      pulse_q <= 1'b0;
    end else begin
      if (ld_stb) per_q <= ld_val;

      if (ld_stb || !tmr_en) pend_q <= 1'b1;
      else if (tk)           pend_q <= 1'b0;

      if (run) cnt_q <= (pend_q || expire) ? per_q : cnt_q - W'(1);

      if (expire)                    flag_q <= 1'b1;
      else if (flag_wr && !flag_wdata) flag_q <= 1'b0;

      if (!tmr_en)  pulse_q <= 1'b0;
      else if (tk)  pulse_q <= expire;
    end
  end

  assign tmr_flag = flag_q;
  assign count    = cnt_q;
  assign irq      = (tmr_ie & (pulse_mode ? pulse_q : flag_q)) | (alm_flag & alm_ie);

endmodule

module prescaled_countdown_chk #(
  parameter int W    = 8,
  parameter int NSRC = 4,
  parameter int SELW = 2
) (
  input logic            clk,
  input logic            rst_n,
  input logic [NSRC-1:0] src_tick,
  input logic [SELW-1:0] src_sel,
  input logic            tmr_en,
  input logic            ld_stb,
  input logic            flag_wr,
  input logic            flag_wdata,
  input logic            tmr_ie,
  input logic            pulse_mode,
  input logic            alm_flag,
  input logic            alm_ie,
  input logic            tmr_flag,
  input logic [W-1:0]    count,
  input logic            irq,
  input logic            pend,
  input logic [W-1:0]    per
);

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_flag && !(flag_wr && !flag_wdata) |=> tmr_flag); // R6

  AST_HOLD_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !tmr_en |=> $stable(count)); // R3

  AST_RESTART_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_en && src_tick[src_sel] && !ld_stb && pend |=> count == $past(per)); // R4

  AST_DECREMENT: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_en && src_tick[src_sel] && !ld_stb && !pend && count > W'(1)
    |=> count == $past(count) - W'(1)); // R5

  AST_LEVEL_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    !pulse_mode && tmr_ie && tmr_flag |-> irq); // R7

  AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !tmr_ie && !(alm_flag && alm_ie) |-> !irq); // R9

  AST_ALARM_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    alm_flag && alm_ie |-> irq); // R9

endmodule

bind prescaled_countdown prescaled_countdown_chk #(.W(W), .NSRC(NSRC), .SELW(SELW)) u_chk (
  .clk(clk), .rst_n(rst_n), .src_tick(src_tick), .src_sel(src_sel),
  .tmr_en(tmr_en), .ld_stb(ld_stb), .flag_wr(flag_wr), .flag_wdata(flag_wdata),
  .tmr_ie(tmr_ie), .pulse_mode(pulse_mode), .alm_flag(alm_flag), .alm_ie(alm_ie),
  .tmr_flag(tmr_flag), .count(count), .irq(irq), .pend(pend_q), .per(per_q)
);

// File: tb/test_prescaled_countdown.sv
module test_prescaled_countdown;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] src_tick = '0;
  logic [1:0] src_sel = '0;
  logic       tmr_en = 1'b0, ld_stb = 1'b0, flag_wr = 1'b0, flag_wdata = 1'b0;
  logic [7:0] ld_val = '0;
  logic       tmr_ie = 1'b0, pulse_mode = 1'b0, alm_flag = 1'b0, alm_ie = 1'b0;
  logic       tmr_flag, irq;
  logic [7:0] count;

  int nchk = 0, nerr = 0, ncyc = 0;

  always #10 clk = ~clk;

  prescaled_countdown i_prescaled_countdown (
    .clk(clk), .rst_n(rst_n), .src_tick(src_tick), .src_sel(src_sel),
    .tmr_en(tmr_en), .ld_stb(ld_stb), .ld_val(ld_val), .flag_wr(flag_wr),
    .flag_wdata(flag_wdata), .tmr_ie(tmr_ie), .pulse_mode(pulse_mode),
    .alm_flag(alm_flag), .alm_ie(alm_ie), .tmr_flag(tmr_flag), .count(count), .irq(irq));

  always @(posedge clk) begin
    ncyc <= ncyc + 1;
    if (ncyc > 20000) begin
      nerr = nerr + 1;
      nchk = nchk + 1;
      $display("FAIL watchdog act=%0d exp=<20000 cycles", ncyc);
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  task automatic chk(string req, int act, int exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic tick(int i);
    src_tick[i] = 1'b1;
    @(negedge clk);
    src_tick = '0;
  endtask

  task automatic load(int v);
    ld_val = 8'(v); ld_stb = 1'b1;
    @(negedge clk);
    ld_stb = 1'b0;
  endtask

  task automatic fwrite(logic d);
    flag_wr = 1'b1; flag_wdata = d;
    @(negedge clk);
    flag_wr = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 count", count, 0);
    chk("R1 flag", tmr_flag, 0);
    chk("R1 irq", irq, 0);
  endtask

  task automatic t_basic();
    src_sel = 2; tmr_en = 1; tmr_ie = 1;
    load(3);
    tick(2); chk("R4 start count", count, 3);
    tick(0); chk("R2 unselected tick", count, 3);
    tick(2); chk("R5 dec", count, 2);
    tick(2); chk("R5 dec", count, 1); chk("R5 no flag yet", tmr_flag, 0);
    tick(2); chk("R5 reload", count, 3); chk("R5 flag set", tmr_flag, 1);
    chk("R7 level irq", irq, 1);
    fwrite(1'b1); chk("R6 write1 ignored", tmr_flag, 1);
    fwrite(1'b0); chk("R6 cleared", tmr_flag, 0); chk("R7 irq follows flag", irq, 0);
  endtask

  task automatic t_disable();
    tick(2); chk("R5 dec", count, 2);
    tmr_en = 0;
    tick(2); chk("R3 hold", count, 2);
    tmr_en = 1;
    tick(2); chk("R4 restart after disable", count, 3);
  endtask

  task automatic t_load();
    tick(2); chk("R5 dec", count, 2);
    load(5); chk("R10 load keeps count", count, 2);
    tick(2); chk("R10 new period", count, 5);
    tick(2); chk("R10 dec", count, 4);
    ld_val = 8'd9; ld_stb = 1; src_tick[2] = 1;
    @(negedge clk);
    ld_stb = 0; src_tick = '0;
    chk("R10 load beats tick", count, 4);
    tick(2); chk("R10 start from 9", count, 9);
  endtask

  task automatic t_pulse();
    tmr_en = 0; @(negedge clk);
    src_sel = 0; pulse_mode = 1;
    load(2); tmr_en = 1;
    tick(0); chk("R4 start", count, 2);
    tick(0); chk("R5 dec", count, 1); chk("R8 no pulse", irq, 0);
    tick(0); chk("R5 reload", count, 2); chk("R8 pulse", irq, 1);
    fwrite(1'b0); chk("R6 clear", tmr_flag, 0); chk("R8 pulse ignores flag", irq, 1);
    tick(0); chk("R8 pulse ends", irq, 0);
    tick(0); chk("R8 second pulse", irq, 1);
    tick(0); chk("R8 flag stays", tmr_flag, 1); chk("R8 pulse over with flag", irq, 0);
  endtask

  task automatic t_sources();
    tmr_en = 0; @(negedge clk);
    src_sel = 3; pulse_mode = 0;
    fwrite(1'b0);
    load(1); tmr_en = 1;
    tick(3); chk("R2 src3 start", count, 1); chk("R2 no flag", tmr_flag, 0);
    tick(1); chk("R2 src1 ignored", tmr_flag, 0);
    tick(3); chk("R5 period1 expiry", tmr_flag, 1); chk("R5 period1 count", count, 1);
    flag_wr = 1; flag_wdata = 0; src_tick[3] = 1;
    @(negedge clk);
    flag_wr = 0; src_tick = '0;
    chk("R6 expiry beats clear", tmr_flag, 1);
    tmr_en = 0; @(negedge clk);
    src_sel = 1; load(4); tmr_en = 1;
    tick(1); chk("R2 src1 start", count, 4);
    tick(3); chk("R2 src3 ignored", count, 4);
  endtask

  task automatic t_alarm();
    tmr_ie = 0; #1;
    chk("R7 ie off", irq, 0);
    alm_flag = 1; alm_ie = 1; #1;
    chk("R9 alarm level", irq, 1);
    pulse_mode = 1; #1;
    chk("R9 alarm in pulse mode", irq, 1);
    alm_ie = 0; #1;
    chk("R9 alarm masked", irq, 0);
    alm_flag = 0;
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_disable();
    t_load();
    t_pulse();
    t_sources();
    t_alarm();
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule